// File: doc/BRIEF.md
# LPC Host SYNC Phase Tracker

This block sits beside the host cycle sequencer of a Low Pin Count bus controller and follows the SYNC phase of each memory, I/O or DMA cycle. After the sequencer has finished the turnaround and pulses `start_i` with the cycle's type, direction and byte count, the block samples the 4-bit LAD nibble on every clock. It sorts each nibble into a wait, ready, ready-more, error, undriven or reserved code. From that code it keeps waiting, moves on to collect the two data nibbles of a read, starts the next byte's SYNC phase, or ends the cycle.

The block counts the bytes that complete. It stops a multi-byte cycle early when a device reports an error. It cuts the cycle off when no device answers or a device drives a code that is not allowed. When the cycle ends it raises a one-clock `done_o` pulse. With that pulse it presents the outcome flags and the byte count, and these stay steady until the next `start_i`.

Top module: `lpc_sync_tracker`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `done_o`, `err_o`, `abort_o`, `dma_more_o` and `byte_vld_o` are low and `bytes_o` is 0. A reset in the middle of a cycle returns the block to idle.
- R2: In idle, LAD is ignored: with no `start_i`, no nibble value produces `done_o` or `byte_vld_o`.
- R3: The wait codes 0101 (short) and 0110 (long) keep the SYNC phase open for any number of clocks. A run of more than eight short waits does not abort the cycle.
- R4: In each SYNC phase, if LAD reads 1111 (undriven) on the first NORESP_CLKS (default 4) clocks, the cycle aborts on the last of those clocks. Fewer 1111 nibbles followed by a valid code let the cycle proceed normally.
- R5: A reserved nibble (anything other than 0000, 0101, 0110, 1001, 1010, 1111) aborts the cycle on the clock it is sampled. So does 1111 once a wait code has been seen in the phase.
- R6: Cycle type is encoded on `cyc_type_i` as 00 I/O, 01 memory, 10 DMA. The code 1001 (ready-more) aborts a non-DMA cycle. On a DMA cycle it completes the byte like ready, and it sets `dma_more_o` when it belongs to the final byte.
- R7: On a read (`rd_i`=1), a ready, ready-more or error code is followed by two data nibbles, low nibble first. The block accepts both, then pulses `byte_vld_o` with the assembled `byte_o`.
- R8: The code 1010 (error) completes the current byte, including its data on a read, and then ends the cycle. `err_o` is set, `dma_more_o` is clear, and `bytes_o` counts that byte, so no later byte is transferred.
- R9: `nbytes_i` (1 to MAX_BYTES) is captured at `start_i`. Each byte has its own SYNC phase with its own no-response window. With no error, the cycle completes after exactly that many bytes, and then `bytes_o` equals that count.
- R10: `done_o` is a one-clock pulse on the clock that samples the cycle's final nibble. `err_o`, `abort_o`, `dma_more_o` and `bytes_o` hold their values until the next `start_i`.
- R11: On an abort, `abort_o` is set, `err_o` and `dma_more_o` are clear, and `bytes_o` holds the number of bytes completed before the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse: SYNC phase of a new cycle begins on the next clock |
| cyc_type_i | input | 2 | 00 I/O, 01 memory, 10 DMA |
| rd_i | input | 1 | 1 when the host reads from the peripheral |
| nbytes_i | input | 3 | Number of bytes in the cycle, 1 to MAX_BYTES |
| lad_i | input | 4 | Sampled LAD nibble |
| done_o | output | 1 | One-clock pulse at the end of the cycle |
| err_o | output | 1 | Cycle ended with an error code |
| abort_o | output | 1 | Cycle aborted (no response or illegal code) |
| dma_more_o | output | 1 | Final DMA byte asked for more transfers |
| bytes_o | output | 3 | Bytes completed in the current or last cycle |
| byte_vld_o | output | 1 | Pulse: a read data byte is on byte_o |
| byte_o | output | 8 | Last read data byte |

## Verification
The main function is tried with nibble streams that each isolate one decision. An immediate ready and a ready after waits tell the sequencing paths apart. Runs of undriven nibbles one short of the window and exactly at it separate the timeout boundary from a normal answer. Long runs of short and of long waits show that waits never time out. Reserved codes, ready-more outside DMA and an undriven nibble after a wait each show an immediate abort. Multi-byte memory and DMA cycles with error on the first or a later byte, or a no-response on the second byte, show early termination, the per-byte timeout window and the byte count reported in each case.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] C_READY = 4'b0000;
  localparam logic [NIB_W-1:0] C_SHORT = 4'b0101;
  localparam logic [NIB_W-1:0] C_LONG  = 4'b0110;
  localparam logic [NIB_W-1:0] C_MORE  = 4'b1001;
  localparam logic [NIB_W-1:0] C_ERR   = 4'b1010;
  localparam logic [NIB_W-1:0] C_FLOAT = 4'b1111;

  localparam logic [1:0] CT_IO  = 2'd0;
  localparam logic [1:0] CT_MEM = 2'd1;
  localparam logic [1:0] CT_DMA = 2'd2;

  typedef enum logic [2:0] {
    SC_READY, SC_MORE, SC_ERR, SC_SHORT, SC_LONG, SC_FLOAT, SC_BAD
  } sync_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SYNC, ST_DLO, ST_DHI
  } sync_st_e;

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
  import lpc_sync_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  input  logic             dma_i,
  output sync_cls_e        cls_o
);

  always_comb begin
    unique case (nib_i)
      C_READY: cls_o = SC_READY;
      C_SHORT: cls_o = SC_SHORT;
      C_LONG:  cls_o = SC_LONG;
      C_ERR:   cls_o = SC_ERR;
      C_FLOAT: cls_o = SC_FLOAT;
      // ready-more only legal on DMA
      C_MORE:  cls_o = dma_i ? SC_MORE : SC_BAD;
      default: cls_o = SC_BAD;
    endcase
  end

endmodule

// File: rtl/lpc_sync_noresp.sv
module lpc_sync_noresp #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,    // window open: in SYNC, no valid code yet
  input  logic float_i,  // nibble reads undriven
  output logic expire_o
);

  if (LIMIT <= 1) begin : g_direct
    assign expire_o = arm_i & float_i;
  end else begin : g_count
    localparam int CNT_W = $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (arm_i && float_i)  cnt_q <= cnt_q + 1'b1;
      else                        cnt_q <= '0;
    end

    assign expire_o = arm_i & float_i & (cnt_q == LAST);
  end

endmodule

// File: rtl/lpc_sync_tracker.sv
module lpc_sync_tracker
  import lpc_sync_pkg::*;
#(
  parameter int MAX_BYTES   = 4,
  parameter int NORESP_CLKS = 4,
  localparam int BYTES_W    = $clog2(MAX_BYTES + 1),
  localparam int DATA_W     = 2 * NIB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         cyc_type_i,
  input  logic               rd_i,
  input  logic [BYTES_W-1:0] nbytes_i,
  input  logic [NIB_W-1:0]   lad_i,
  output logic               done_o,
  output logic               err_o,
  output logic               abort_o,
  output logic               dma_more_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               byte_vld_o,
  output logic [DATA_W-1:0]  byte_o
);

  sync_st_e           st_q, st_d;
  logic               seen_q, seen_d;
  logic               errp_q, errp_d;
  logic               morep_q, morep_d;
  logic               dma_q, dma_d;
  logic               rd_q, rd_d;
  logic [BYTES_W-1:0] nb_q, nb_d;
  logic [BYTES_W-1:0] cnt_q, cnt_d;
  logic [NIB_W-1:0]   lo_q, lo_d;
  logic               err_d, abort_d, more_d, bvld_d;
  logic [DATA_W-1:0]  byte_d;

  sync_cls_e          cls;
  logic               in_sync;
  logic               expire;
  logic               fin, fin_err, fin_more, do_abort;
  logic [BYTES_W-1:0] cnt_inc;

  assign in_sync = (st_q == ST_SYNC);
  assign cnt_inc = cnt_q + 1'b1;

  lpc_sync_decode i_decode (
    .nib_i (lad_i),
    .dma_i (dma_q),
    .cls_o (cls)
  );

  lpc_sync_noresp #(.LIMIT(NORESP_CLKS)) i_noresp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (in_sync && !seen_q),
    .float_i  (cls == SC_FLOAT),
    .expire_o (expire)
  );

  always_comb begin
    st_d     = st_q;
    seen_d   = seen_q;
    errp_d   = errp_q;
    morep_d  = morep_q;
    dma_d    = dma_q;
    rd_d     = rd_q;
    nb_d     = nb_q;
    cnt_d    = cnt_q;
    lo_d     = lo_q;
    err_d    = err_o;
    abort_d  = abort_o;
    more_d   = dma_more_o;
    byte_d   = byte_o;
    bvld_d   = 1'b0;
    fin      = 1'b0;
    fin_err  = 1'b0;
    fin_more = 1'b0;
    do_abort = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_SYNC;
          seen_d  = 1'b0;
          dma_d   = (cyc_type_i == CT_DMA);
          rd_d    = rd_i;
          nb_d    = nbytes_i;
          cnt_d   = '0;
          err_d   = 1'b0;
          abort_d = 1'b0;
          more_d  = 1'b0;
        end
      end
      ST_SYNC: begin
        unique case (cls)
          SC_SHORT, SC_LONG: seen_d = 1'b1;
          // undriven: timeout before any wait, illegal after one
          SC_FLOAT: do_abort = seen_q || expire;
          SC_BAD:   do_abort = 1'b1;
          default: begin
            if (rd_q) begin
              errp_d  = (cls == SC_ERR);
              morep_d = (cls == SC_MORE);
              st_d    = ST_DLO;
            end else begin
              fin      = 1'b1;
              fin_err  = (cls == SC_ERR);
              fin_more = (cls == SC_MORE);
            end
          end
        endcase
      end
      ST_DLO: begin
        lo_d = lad_i;
        st_d = ST_DHI;
      end
      default: begin
        byte_d   = {lad_i, lo_q};
        bvld_d   = 1'b1;
        fin      = 1'b1;
        fin_err  = errp_q;
        fin_more = morep_q;
      end
    endcase

    if (do_abort) begin
      st_d    = ST_IDLE;
      abort_d = 1'b1;
      err_d   = 1'b0;
      more_d  = 1'b0;
    end else if (fin) begin
      cnt_d = cnt_inc;
      if (fin_err || cnt_inc == nb_q) begin
        st_d   = ST_IDLE;
        err_d  = fin_err;
        more_d = fin_more && !fin_err;
      end else begin
        st_d   = ST_SYNC;
        seen_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      seen_q     <= 1'b0;
      errp_q     <= 1'b0;
      morep_q    <= 1'b0;
      dma_q      <= 1'b0;
      rd_q       <= 1'b0;
      nb_q       <= '0;
      cnt_q      <= '0;
      lo_q       <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      abort_o    <= 1'b0;
      dma_more_o <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      st_q       <= st_d;
      seen_q     <= seen_d;
      errp_q     <= errp_d;
      morep_q    <= morep_d;
      dma_q      <= dma_d;
      rd_q       <= rd_d;
      nb_q       <= nb_d;
      cnt_q      <= cnt_d;
      lo_q       <= lo_d;
      done_o     <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
      err_o      <= err_d;
      abort_o    <= abort_d;
      dma_more_o <= more_d;
      byte_vld_o <= bvld_d;
      byte_o     <= byte_d;
    end
  end

  assign bytes_o = cnt_q;

endmodule

// File: rtl/lpc_sync_checker.sv
module lpc_sync_checker #(
  parameter int BYTES_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         lad_i,
  input logic               in_sync_i,
  input logic               dma_i,
  input logic [BYTES_W-1:0] nb_i,
  input logic               done_i,
  input logic               err_i,
  input logic               abort_i,
  input logic               more_i,
  input logic [BYTES_W-1:0] bytes_i
);

  logic reserved;
  assign reserved = !(lad_i inside {4'b0000, 4'b0101, 4'b0110, 4'b1001, 4'b1010, 4'b1111});

  p_wait_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sync_i && (lad_i == 4'b0101 || lad_i == 4'b0110) |=> !done_i && in_sync_i);

  p_reserved_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sync_i && reserved |=> done_i && abort_i);

  p_more_non_dma_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sync_i && lad_i == 4'b1001 && !dma_i |=> done_i && abort_i);

  p_err_clears_more_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && err_i |-> !more_i && !abort_i);

  p_full_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !err_i && !abort_i |-> bytes_i == nb_i);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_abort_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && abort_i |-> !err_i && !more_i);

endmodule

bind lpc_sync_tracker lpc_sync_checker #(.BYTES_W(BYTES_W)) i_lpc_sync_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lad_i     (lad_i),
  .in_sync_i (in_sync),
  .dma_i     (dma_q),
  .nb_i      (nb_q),
  .done_i    (done_o),
  .err_i     (err_o),
  .abort_i   (abort_o),
  .more_i    (dma_more_o),
  .bytes_i   (bytes_o)
);

// File: tb/test_lpc_sync_tracker.sv
`timescale 1ns/1ps
module test_lpc_sync_tracker;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] cyc_type_i = 2'd0;
  logic       rd_i = 1'b0;
  logic [2:0] nbytes_i = 3'd1;
  logic [3:0] lad_i = 4'hF;
  logic       done_o, err_o, abort_o, dma_more_o, byte_vld_o;
  logic [2:0] bytes_o;
  logic [7:0] byte_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lpc_sync_tracker i_lpc_sync_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cyc_type_i(cyc_type_i),
    .rd_i(rd_i), .nbytes_i(nbytes_i), .lad_i(lad_i), .done_o(done_o),
    .err_o(err_o), .abort_o(abort_o), .dma_more_o(dma_more_o),
    .bytes_o(bytes_o), .byte_vld_o(byte_vld_o), .byte_o(byte_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  typ;
    logic        rd;
    logic [2:0]  nb;
    logic [7:0]  len;
    logic [63:0] nib;   // nibble k at [4k+:4]
    logic        err;
    logic        ab;
    logic        more;
    logic [2:0]  bytes;
    logic [7:0]  data;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'd10, 2'd0, 1'b0, 3'd1, 8'd1,  64'h0,           1'b0, 1'b0, 1'b0, 3'd1, 8'h00}, // R10 io write
    '{8'd7,  2'd0, 1'b1, 3'd1, 8'd5,  64'hC3055,       1'b0, 1'b0, 1'b0, 3'd1, 8'hC3}, // R7 read after waits
    '{8'd4,  2'd0, 1'b1, 3'd1, 8'd4,  64'hFFFF,        1'b0, 1'b1, 1'b0, 3'd0, 8'h00}, // R4 no response
    '{8'd4,  2'd0, 1'b0, 3'd1, 8'd4,  64'h0FFF,        1'b0, 1'b0, 1'b0, 3'd1, 8'h00}, // R4 one short of window
    '{8'd3,  2'd0, 1'b0, 3'd1, 8'd11, 64'h05555555555, 1'b0, 1'b0, 1'b0, 3'd1, 8'h00}, // R3 ten short waits
    '{8'd3,  2'd1, 1'b0, 3'd1, 8'd11, 64'h06666666666, 1'b0, 1'b0, 1'b0, 3'd1, 8'h00}, // R3 long waits
    '{8'd5,  2'd0, 1'b0, 3'd1, 8'd2,  64'h35,          1'b0, 1'b1, 1'b0, 3'd0, 8'h00}, // R5 reserved code
    '{8'd6,  2'd0, 1'b0, 3'd1, 8'd1,  64'h9,           1'b0, 1'b1, 1'b0, 3'd0, 8'h00}, // R6 more on io
    '{8'd6,  2'd2, 1'b0, 3'd1, 8'd1,  64'h9,           1'b0, 1'b0, 1'b1, 3'd1, 8'h00}, // R6 more on dma
    '{8'd9,  2'd2, 1'b1, 3'd2, 8'd6,  64'h439210,      1'b0, 1'b0, 1'b1, 3'd2, 8'h43}, // R9 dma read 2
    '{8'd8,  2'd1, 1'b1, 3'd4, 8'd3,  64'h65A,         1'b1, 1'b0, 1'b0, 3'd1, 8'h65}, // R8 err on first of 4
    '{8'd9,  2'd1, 1'b0, 3'd4, 8'd5,  64'h00050,       1'b0, 1'b0, 1'b0, 3'd4, 8'h00}, // R9 mem write 4
    '{8'd8,  2'd2, 1'b0, 3'd2, 8'd2,  64'hA0,          1'b1, 1'b0, 1'b0, 3'd2, 8'h00}, // R8 dma err 2nd
    '{8'd5,  2'd0, 1'b0, 3'd1, 8'd2,  64'hF5,          1'b0, 1'b1, 1'b0, 3'd0, 8'h00}, // R5 float after wait
    '{8'd11, 2'd1, 1'b0, 3'd2, 8'd5,  64'hFFFF0,       1'b0, 1'b1, 1'b0, 3'd1, 8'h00}  // R11 abort on 2nd byte
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    string tag;
    int first_done, vcnt;
    logic [7:0] last_byte;
    logic idle_hit;

    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "done in reset", done_o, 0);
    chk("R1", "flags in reset", {err_o, abort_o, dma_more_o, byte_vld_o}, 0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1", "bytes after reset", bytes_o, 0);

    // R2 idle ignores LAD
    idle_hit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) lad_i = (k == 0) ? 4'h0 : (k == 1) ? 4'hA : (k == 2) ? 4'h9 : 4'h3;
      @(posedge clk); #1;
      if (done_o || byte_vld_o) idle_hit = 1'b1;
    end
    chk("R2", "idle activity", idle_hit, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      tag = $sformatf("R%0d v%0d", VECS[v].req, v);
      @(negedge clk);
      start_i = 1'b1; cyc_type_i = VECS[v].typ; rd_i = VECS[v].rd;
      nbytes_i = VECS[v].nb; lad_i = 4'hF;
      @(posedge clk);
      first_done = -1; vcnt = 0; last_byte = 8'h00;
      for (int k = 0; k < int'(VECS[v].len); k++) begin
        @(negedge clk);
        start_i = 1'b0;
        lad_i = VECS[v].nib[4*k +: 4];
        @(posedge clk); #1;
        if (done_o && first_done < 0) first_done = k;
        if (byte_vld_o) begin vcnt++; last_byte = byte_o; end
      end
      @(negedge clk) lad_i = 4'hF;
      chk(tag, "done clock", first_done, int'(VECS[v].len) - 1);
      chk(tag, "err_o", err_o, VECS[v].err);
      chk(tag, "abort_o", abort_o, VECS[v].ab);
      chk(tag, "dma_more_o", dma_more_o, VECS[v].more);
      chk(tag, "bytes_o", bytes_o, VECS[v].bytes);
      chk(tag, "byte_vld count", vcnt, VECS[v].rd ? int'(VECS[v].bytes) : 0);
      if (VECS[v].rd && VECS[v].bytes != 0)
        chk(tag, "byte_o", last_byte, VECS[v].data);
    end

    // R10 flags hold after done until next start
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "abort held", abort_o, 1);
    chk("R10", "bytes held", bytes_o, 1);
    chk("R10", "done single pulse", done_o, 0);

    // R1 reset mid-cycle, then R2 idle ignores a ready code
    @(negedge clk);
    start_i = 1'b1; cyc_type_i = 2'd0; rd_i = 1'b0; nbytes_i = 3'd1; lad_i = 4'hF;
    @(negedge clk);
    start_i = 1'b0; lad_i = 4'h5;
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk) rst_ni = 1'b1;
    #1;
    chk("R1", "mid-cycle reset flags", {done_o, err_o, abort_o, dma_more_o}, 0);
    chk("R1", "mid-cycle reset bytes", bytes_o, 0);
    idle_hit = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) lad_i = 4'h0;
      @(posedge clk); #1;
      if (done_o) idle_hit = 1'b1;
    end
    chk("R2", "ready code after reset ignored", idle_hit, 0);

    summary();
  end

endmodule